// File: doc/BRIEF.md
# Watermark-Gated DMA Request Controller

This block decides when a frame controller asks the host bus for DMA on its receive and transmit FIFOs. Receive DMA is requested once the receive FIFO holds at least N 16-bit words, or as soon as an end-of-frame word has landed in it. Transmit DMA is requested once the transmit FIFO has room for at least N words. N comes from a 2-bit threshold code in a small configuration register.

Each request lasts for one bus tenure. The tenure ends when one of these happens:
- a programmable count of word transfers has been made;
- the frame-end word has been moved (receive only);
- the FIFO runs dry on receive, or fills on transmit.

The same threshold can hold back the start of a new transmit frame until enough of it is queued. A per-transfer swap enable tells the datapath whether to exchange the two byte lanes of each 16-bit word. Two separate configuration bits choose the swap, one for frame-data transfers and one for descriptor, status and setup-block transfers.

The FIFOs, address generation and serial framing sit outside this block. The block sees the FIFO levels, the frame-end flags, the bus grant and a per-beat transfer strobe.

Top module: `dma_wm_gate`

## Requirements
- R1: The 8-bit configuration register is written from `cfg_wdata` on a clock edge with `cfg_we` high and reads back on `cfg_rdata` from the next cycle. Reset clears every bit. Field layout: [1:0] threshold code, [3:2] burst code, [4] byte mode (1 = 8-bit bus), [5] swap for non-data transfers, [6] swap for data transfers, [7] transmit hold-off enable.
- R2: The threshold N in words is 4 for code 01, 8 for code 10 and 16 for code 11. Code 00 is reserved and behaves as 16.
- R3: From idle, `rx_req` goes high one cycle after a clock edge at which `rx_level` >= N or `rx_eof_seen` is high. Receive takes priority over transmit.
- R4: From idle, `tx_req` goes high one cycle after a clock edge at which the receive condition is false and `tx_free` >= N.
- R5: A beat is an edge with `xfer_done` and `bus_grant` both high while a request is active. The request drops right after the beat that reaches the burst limit. In 16-bit mode the burst codes 01, 10 and 11 give limits of 2, 4 and 8 beats. Byte mode doubles each of these limits. Code 00 means no limit.
- R6: An active receive request drops after a beat with `xfer_eof` high, or after an edge at which `rx_level` is 0.
- R7: An active transmit request drops after an edge at which `tx_free` is 0.
- R8: After a request drops, both requests stay low for at least one cycle before either can rise.
- R9: `swap_en` equals the data swap bit when `xfer_is_data` is high, and the non-data swap bit otherwise, in the same cycle.
- R10: `tx_start_ok` is high when the hold-off bit is clear, or when `tx_level` >= N, or when `tx_frame_whole` is high, in the same cycle.
- R11: `rx_req` and `tx_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low bus reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration readback |
| rx_level | input | LVL_W | Words held in the receive FIFO |
| rx_eof_seen | input | 1 | A frame-end word is in the receive FIFO |
| tx_free | input | LVL_W | Free word slots in the transmit FIFO |
| tx_level | input | LVL_W | Words held in the transmit FIFO |
| tx_frame_whole | input | 1 | The whole current transmit frame is in the FIFO |
| bus_grant | input | 1 | Host bus granted to this controller |
| xfer_done | input | 1 | One word transfer completes this cycle |
| xfer_eof | input | 1 | The word moved this cycle is a frame end |
| xfer_is_data | input | 1 | Current transfer targets a data buffer |
| rx_req | output | 1 | Receive DMA request |
| tx_req | output | 1 | Transmit DMA request |
| swap_en | output | 1 | Exchange byte lanes for this transfer |
| tx_start_ok | output | 1 | A new transmit frame may begin |

## Verification
The requests and the configuration readback are registered. A condition present at a clock edge therefore shows at the ports one cycle later, and the terminating beat removes the request in the same way. `swap_en` and `tx_start_ok` follow their inputs within the same cycle. The bench changes inputs two time units after a rising edge and updates its reference model on the rising edge, using the values held from the previous cycle. It compares every output at the falling edge, so each registered result is checked in the first cycle it is due and each combinational result in the cycle of its stimulus.

// File: rtl/dmag_pkg.sv
package dmag_pkg;

  localparam int CFG_W     = 8;
  localparam int BURST_MAX = 16;
  localparam int CNT_W     = $clog2(BURST_MAX + 1);

  typedef struct packed {
    logic       hold_en;
    logic       swap_data;
    logic       swap_ctl;
    logic       byte_mode;
    logic [1:0] burst;
    logic [1:0] thresh;
  } dmag_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_TX   = 2'd2
  } dmag_state_t;

  // Threshold in words; the reserved code falls back to the largest value.
  function automatic int unsigned thresh_words(logic [1:0] code);
    case (code)
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 16;
    endcase
  endfunction

  // Beats per tenure; zero means no cap. Byte-wide buses need twice the beats.
  function automatic int unsigned burst_beats(logic [1:0] code, logic byte_mode);
    int unsigned base;
    case (code)
      2'b01:   base = 2;
      2'b10:   base = 4;
      2'b11:   base = 8;
      default: base = 0;
    endcase
    return byte_mode ? base * 2 : base;
  endfunction

endpackage

// File: rtl/dmag_cfg_reg.sv
module dmag_cfg_reg
  import dmag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output dmag_cfg_t        cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= dmag_cfg_t'(wdata);
  end

endmodule

// File: rtl/dmag_burst_fsm.sv
module dmag_burst_fsm
  import dmag_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_go,
  input  logic          tx_go,
  input  logic          beat,
  input  logic          eof_beat,
  input  logic          rx_dry,
  input  logic          tx_full,
  input  logic [CW-1:0] limit,
  output logic          rx_req,
  output logic          tx_req,
  output logic          cap_hit
);

  dmag_state_t   st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;

  assign cnt_nx  = cnt_q + CW'(beat);
  assign cap_hit = (limit != '0) && (cnt_nx >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (rx_go)      st_q <= ST_RX;
          else if (tx_go) st_q <= ST_TX;
        end
        ST_RX: begin
          cnt_q <= cnt_nx;
          if (cap_hit || eof_beat || rx_dry) st_q <= ST_IDLE;
        end
        ST_TX: begin
          cnt_q <= cnt_nx;
          if (cap_hit || tx_full) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rx_req = (st_q == ST_RX);
  assign tx_req = (st_q == ST_TX);

endmodule

// File: rtl/dmag_lane_sel.sv
module dmag_lane_sel #(
  parameter int LW = 6
) (
  input  logic          swap_ctl,
  input  logic          swap_data,
  input  logic          is_data,
  input  logic          hold_en,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] n_words,
  input  logic          frame_whole,
  output logic          swap_en,
  output logic          start_ok
);

  always_comb begin
    swap_en  = is_data ? swap_data : swap_ctl;
    start_ok = !hold_en || (tx_level >= n_words) || frame_whole;
  end

endmodule

// File: rtl/dma_wm_gate.sv
module dma_wm_gate
  import dmag_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_eof_seen,
  input  logic [LVL_W-1:0] tx_free,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             tx_frame_whole,
  input  logic             bus_grant,
  input  logic             xfer_done,
  input  logic             xfer_eof,
  input  logic             xfer_is_data,
  output logic             rx_req,
  output logic             tx_req,
  output logic             swap_en,
  output logic             tx_start_ok
);

  dmag_cfg_t        cfg_q;
  logic [LVL_W-1:0] n_words;
  logic [CNT_W-1:0] burst_lim;
  // Named internal events, brought out for the checker.
  logic             rx_go;
  logic             tx_go;
  logic             beat;
  logic             eof_beat;
  logic             cap_hit;

  dmag_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg_q (cfg_q)
  );

  assign cfg_rdata = cfg_q;
  assign n_words   = LVL_W'(thresh_words(cfg_q.thresh));
  assign burst_lim = CNT_W'(burst_beats(cfg_q.burst, cfg_q.byte_mode));
  assign rx_go     = (rx_level >= n_words) || rx_eof_seen;
  assign tx_go     = (tx_free >= n_words);
  assign beat      = xfer_done && bus_grant;
  assign eof_beat  = beat && xfer_eof;

  dmag_burst_fsm #(.CW(CNT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_go    (rx_go),
    .tx_go    (tx_go),
    .beat     (beat),
    .eof_beat (eof_beat),
    .rx_dry   (rx_level == '0),
    .tx_full  (tx_free == '0),
    .limit    (burst_lim),
    .rx_req   (rx_req),
    .tx_req   (tx_req),
    .cap_hit  (cap_hit)
  );

  dmag_lane_sel #(.LW(LVL_W)) u_lane (
    .swap_ctl    (cfg_q.swap_ctl),
    .swap_data   (cfg_q.swap_data),
    .is_data     (xfer_is_data),
    .hold_en     (cfg_q.hold_en),
    .tx_level    (tx_level),
    .n_words     (n_words),
    .frame_whole (tx_frame_whole),
    .swap_en     (swap_en),
    .start_ok    (tx_start_ok)
  );

endmodule

// File: rtl/dma_wm_gate_chk.sv
module dma_wm_gate_chk #(
  parameter int LW = 6,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_req,
  input logic          tx_req,
  input logic          rx_go,
  input logic          beat,
  input logic          eof_beat,
  input logic [CW-1:0] limit,
  input logic [LW-1:0] tx_free,
  input logic          swap_ctl_q,
  input logic          swap_data_q,
  input logic          hold_q,
  input logic          is_data,
  input logic          swap_en,
  input logic          tx_start_ok
);

  logic [CW:0] beats_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   beats_seen <= '0;
    else if (!(rx_req || tx_req)) beats_seen <= '0;
    else if (beat)                beats_seen <= beats_seen + 1'b1;
  end

  assert_req_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_req && tx_req));

  assert_rx_start_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_req) |-> $past(rx_go));

  assert_burst_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0 && beats_seen >= {1'b0, limit}) |-> !(rx_req || tx_req));

  assert_eof_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && eof_beat) |=> !rx_req);

  assert_tx_full_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_free == '0) |=> !tx_req);

  assert_gap_after_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_req) |-> !tx_req);

  assert_gap_after_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_req) |-> !rx_req);

  assert_swap_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en == (is_data ? swap_data_q : swap_ctl_q));

  assert_no_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |-> tx_start_ok);

endmodule

bind dma_wm_gate dma_wm_gate_chk #(.LW(LVL_W), .CW(dmag_pkg::CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_req      (rx_req),
  .tx_req      (tx_req),
  .rx_go       (rx_go),
  .beat        (beat),
  .eof_beat    (eof_beat),
  .limit       (burst_lim),
  .tx_free     (tx_free),
  .swap_ctl_q  (cfg_rdata[5]),
  .swap_data_q (cfg_rdata[6]),
  .hold_q      (cfg_rdata[7]),
  .is_data     (xfer_is_data),
  .swap_en     (swap_en),
  .tx_start_ok (tx_start_ok)
);

// File: tb/test_dma_wm_gate.sv
`timescale 1ns/1ps
module test_dma_wm_gate;

  localparam int LW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic [LW-1:0] rx_level = '0;
  logic          rx_eof_seen = 1'b0;
  logic [LW-1:0] tx_free = '0;
  logic [LW-1:0] tx_level = '0;
  logic          tx_frame_whole = 1'b0;
  logic          bus_grant = 1'b0;
  logic          xfer_done = 1'b0;
  logic          xfer_eof = 1'b0;
  logic          xfer_is_data = 1'b0;
  logic          rx_req, tx_req, swap_en, tx_start_ok;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_wm_gate i_dma_wm_gate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rx_level(rx_level), .rx_eof_seen(rx_eof_seen),
    .tx_free(tx_free), .tx_level(tx_level), .tx_frame_whole(tx_frame_whole),
    .bus_grant(bus_grant), .xfer_done(xfer_done), .xfer_eof(xfer_eof),
    .xfer_is_data(xfer_is_data), .rx_req(rx_req), .tx_req(tx_req),
    .swap_en(swap_en), .tx_start_ok(tx_start_ok)
  );

  // Threshold per R2, written as a shift; reserved 0 maps to 16.
  function automatic int ref_n(int code);
    return (code == 0) ? 16 : (2 << code);
  endfunction

  // Beat cap per R5.
  function automatic int ref_lim(int code, int bytemode);
    if (code == 0) return 0;
    return (1 << code) * (bytemode != 0 ? 2 : 1);
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Reference model: mode 0 idle, 1 receive tenure, 2 transmit tenure.
  int       m_mode;
  int       m_beats;
  bit [7:0] m_cfg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_beats = 0; m_cfg = 8'h00;
    end else begin
      int n, lim;
      bit b;
      n   = ref_n(int'(m_cfg[1:0]));
      lim = ref_lim(int'(m_cfg[3:2]), int'(m_cfg[4]));
      b   = xfer_done && bus_grant;
      if (m_mode == 0) begin
        m_beats = 0;
        if (int'(rx_level) >= n || rx_eof_seen) m_mode = 1;
        else if (int'(tx_free) >= n)            m_mode = 2;
      end else begin
        if (b) m_beats++;
        if (lim != 0 && m_beats >= lim)             m_mode = 0;
        else if (m_mode == 1 && b && xfer_eof)      m_mode = 0;
        else if (m_mode == 1 && rx_level == '0)     m_mode = 0;
        else if (m_mode == 2 && tx_free == '0)      m_mode = 0;
      end
      if (cfg_we) m_cfg = cfg_wdata;
    end
  end

  // Compare every cycle, mid-period.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1",  int'(cfg_rdata), int'(m_cfg));
      chk("R3",  int'(rx_req), int'(m_mode == 1));
      chk("R4",  int'(tx_req), int'(m_mode == 2));
      chk("R11", int'(rx_req && tx_req), 0);
      chk("R9",  int'(swap_en), int'(xfer_is_data ? m_cfg[6] : m_cfg[5]));
      chk("R10", int'(tx_start_ok),
          int'(!m_cfg[7] || int'(tx_level) >= ref_n(int'(m_cfg[1:0])) || tx_frame_whole));
    end
  end

  task automatic edge_drive();
    @(posedge clk); #2;
  endtask

  task automatic wr_cfg(bit [7:0] v);
    edge_drive(); cfg_we = 1'b1; cfg_wdata = v;
    edge_drive(); cfg_we = 1'b0;
  endtask

  task automatic after_edge();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run_len(output int len);
    int guard;
    guard = 0; len = 0;
    @(negedge clk);
    while (!rx_req && guard < 50) begin @(negedge clk); guard++; end
    while (rx_req && len < 100) begin len++; @(negedge clk); end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got hung expected done");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int len;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", int'(cfg_rdata), 0);
    chk("R3 reset", int'(rx_req || tx_req), 0);

    wr_cfg(8'hA5); @(negedge clk);
    chk("R1 readback", int'(cfg_rdata), 8'hA5);
    wr_cfg(8'h00);

    // R2: below, at, above threshold for every code.
    for (int code = 0; code < 4; code++) begin
      int n;
      n = ref_n(code);
      wr_cfg(8'(code));
      edge_drive(); rx_level = LW'(n - 1);
      repeat (3) after_edge();
      chk("R2 below", int'(rx_req), 0);
      edge_drive(); rx_level = LW'(n);
      after_edge();
      chk("R2 at", int'(rx_req), 1);
      edge_drive(); rx_level = '0;
      after_edge();
      chk("R6 dry", int'(rx_req), 0);
      edge_drive(); rx_level = LW'(n + 1);
      after_edge();
      chk("R2 above", int'(rx_req), 1);
      edge_drive(); rx_level = '0;
      repeat (2) after_edge();
    end

    // R6: frame end opens a short burst that closes on the frame-end beat.
    wr_cfg(8'h03);
    edge_drive(); rx_level = LW'(2); rx_eof_seen = 1'b1;
    @(posedge clk); #2;
    bus_grant = 1'b1; xfer_done = 1'b1; xfer_eof = 1'b1;
    @(negedge clk);
    chk("R6 eof open", int'(rx_req), 1);
    @(posedge clk); #2;
    rx_eof_seen = 1'b0; rx_level = '0; xfer_eof = 1'b0; xfer_done = 1'b0;
    @(negedge clk);
    chk("R6 eof close", int'(rx_req), 0);
    repeat (2) after_edge();

    // R5: burst caps in both bus widths, then unlimited.
    begin
      bit [7:0] cfgs [3] = '{8'h05, 8'h1D, 8'h19};
      int       exps [3] = '{2, 16, 8};
      for (int i = 0; i < 3; i++) begin
        wr_cfg(cfgs[i]);
        edge_drive(); rx_level = LW'(20); bus_grant = 1'b1; xfer_done = 1'b1;
        run_len(len);
        chk("R5 cap", len, exps[i]);
        chk("R8 gap", int'(rx_req || tx_req), 0);
        @(negedge clk);
        chk("R8 restart", int'(rx_req), 1);
        edge_drive(); rx_level = '0; xfer_done = 1'b0;
        repeat (2) after_edge();
      end
    end
    wr_cfg(8'h01);
    edge_drive(); rx_level = LW'(20); xfer_done = 1'b1;
    repeat (30) after_edge();
    chk("R5 unlimited", int'(rx_req), 1);
    edge_drive(); rx_level = '0; xfer_done = 1'b0; bus_grant = 1'b0;
    repeat (2) after_edge();

    // R4 / R7 / R11: transmit side.
    wr_cfg(8'h02);
    edge_drive(); tx_free = LW'(7);
    repeat (3) after_edge();
    chk("R4 below", int'(tx_req), 0);
    edge_drive(); tx_free = LW'(8);
    after_edge();
    chk("R4 at", int'(tx_req), 1);
    edge_drive(); tx_free = '0;
    after_edge();
    chk("R7 full", int'(tx_req), 0);
    edge_drive(); tx_free = LW'(9); rx_level = LW'(8);
    after_edge();
    chk("R11 rx wins", int'(rx_req), 1);
    chk("R11 tx held", int'(tx_req), 0);
    edge_drive(); tx_free = '0; rx_level = '0;
    repeat (2) after_edge();

    // R9: both swap bits against both transfer classes.
    for (int s = 0; s < 4; s++) begin
      wr_cfg(8'(s << 5));
      for (int d = 0; d < 2; d++) begin
        edge_drive(); xfer_is_data = (d != 0);
        @(negedge clk);
        chk("R9 swap", int'(swap_en), (d != 0) ? ((s >> 1) & 1) : (s & 1));
      end
    end

    // R10: transmit hold-off.
    wr_cfg(8'h81);
    edge_drive(); tx_level = LW'(3);
    @(negedge clk); chk("R10 held", int'(tx_start_ok), 0);
    edge_drive(); tx_level = LW'(4);
    @(negedge clk); chk("R10 at", int'(tx_start_ok), 1);
    edge_drive(); tx_level = LW'(3); tx_frame_whole = 1'b1;
    @(negedge clk); chk("R10 whole", int'(tx_start_ok), 1);
    edge_drive(); tx_frame_whole = 1'b0;
    @(negedge clk); chk("R10 held again", int'(tx_start_ok), 0);
    wr_cfg(8'h01);
    @(negedge clk); chk("R10 off", int'(tx_start_ok), 1);

    repeat (3) after_edge();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule